// File: doc/BRIEF.md
# Indexed Framebuffer Display Controller

This block drives a 640x480 raster at 72 Hz (31.5 MHz pixel rate) and shows one of twelve stored 64x64 images in the middle of the screen. Each image pixel is a 4-bit index into a sixteen-entry colour table. Every table entry holds a 6-bit colour with two bits each for red, green and blue, in that order from the top bit down. Each source pixel is drawn as a 6x6 block, so the image covers a 384x384 window. The window starts at column 128 and row 48. Outside the window, and while the display is switched off, the colour output is zero.

A processor programs the block through a write-only register window at base address 0x30000000. The processor loads image words through a streaming data register, and a word pointer advances by one after each write. It then fills the colour table, picks a frame and switches the display on. Animation is done by rewriting the frame select.

One clock runs the whole block, and a pixel enable input paces it. On every enabled cycle the scan position advances by one pixel. The colour path takes two enabled cycles. The first works out the image word from the scan position. The second reads that word, picks the 4-bit index and looks it up in the colour table. The sync outputs are delayed by the same two cycles, so they line up with the colour.

Top module: `idx_vga_display`

## Requirements
- R1: After reset, hsync_n and vsync_n are 1, color is 0, the display is off, frame 0 is selected and the word pointer is at word 0.
- R2: The column counter advances on each enabled cycle through 832 positions (640 visible, 24 front porch, 40 sync, 128 back porch). hsync_n is low at columns 664 to 703.
- R3: The row counter advances when the column wraps, through 520 rows (480 visible, 9 front porch, 3 sync, 28 back porch). vsync_n is low at rows 489 to 491.
- R4: While pix_en is 0, the scan position, color, hsync_n and vsync_n all hold their values.
- R5: color is non-zero only at columns 128 to 511 and rows 48 to 431. At such a position the source pixel is column (x-128)/6 and row (y-48)/6.
- R6: Source pixel (c, r) of frame f is stored in word f*512 + r*8 + c/8, at bits 4*(c%8)+3 down to 4*(c%8).
- R7: A write to offset 0x40+4n (n from 0 to 15) stores bits 5:0 of the data as colour table entry n. A displayed pixel with index n shows entry n.
- R8: A write to offset 0x00 sets the display enable from bit 0. While the display is off, color is 0.
- R9: The same write loads the frame select from bits 7:4 when that value is below the frame count. A value of 12 or more leaves the previous frame selected.
- R10: A write to offset 0x04 stores the data at the pointer word and then advances the pointer, wrapping from the last word of the last frame to word 0. A write to offset 0x00 with bit 8 set returns the pointer to word 0.
- R11: A write whose address bits 31:8 differ from the base, or whose offset is not one of those above, changes nothing.
- R12: The colour and both syncs for a scan position appear two enabled cycles after the counters reach that position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Pixel enable; one pixel per enabled cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 32 | Register write byte address |
| bus_data | input | 32 | Register write data |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| color | output | 6 | Pixel colour, red 5:4, green 3:2, blue 1:0 |

## Verification
On every cycle the assertions check the following. Outputs freeze while the pixel enable is low. A position the first stage marks as blank or disabled gives zero colour one enabled cycle later. The frame select never leaves the stored range. The word pointer steps by one or wraps on each streaming write. Writes outside the base change no control state. The exact sync placement, the window bounds, the 6x replication, the nibble packing, the table lookup and the pointer wrap into earlier words are shown only by the bench scenarios. In those scenarios the behavioural model checks every pixel of whole frames under several enable patterns, frame choices and register sequences.

// File: rtl/vga_idx_pkg.sv
package vga_idx_pkg;

  // register offsets inside the 256-byte window
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_STREAM = 8'h04;
  localparam logic [1:0] OFS_PAL_HI = 2'b01;   // offsets 0x40..0x7C

  // control word fields
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_FR_LSB   = 4;
  localparam int CTRL_PTR0_BIT = 8;

  localparam int PIX_PER_WORD = 8;
  localparam int PAL_ENTRIES  = 16;
  localparam int COLOR_W      = 6;

  // select the 4-bit index at slot sel of a packed word
  function automatic logic [3:0] pick_nibble(input logic [31:0] w, input logic [2:0] sel);
    logic [31:0] sh;
    sh = w >> {sel, 2'b00};
    return sh[3:0];
  endfunction

  // true when pos lies inside [lo, lo+len)
  function automatic logic in_span(input int pos, input int lo, input int len);
    return (pos >= lo) && (pos < lo + len);
  endfunction

endpackage

// File: rtl/vga_scan_timer.sv
module vga_scan_timer #(
  parameter int H_VIS = 640,
  parameter int H_FP  = 24,
  parameter int H_SY  = 40,
  parameter int H_BP  = 128,
  parameter int V_VIS = 480,
  parameter int V_FP  = 9,
  parameter int V_SY  = 3,
  parameter int V_BP  = 28,
  localparam int H_TOT = H_VIS + H_FP + H_SY + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SY + V_BP,
  localparam int HW = $clog2(H_TOT),
  localparam int VW = $clog2(V_TOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  output logic [HW-1:0] hpos,
  output logic [VW-1:0] vpos,
  output logic          hs_raw_n,
  output logic          vs_raw_n
);
  import vga_idx_pkg::*;

  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);

  logic line_wrap;
  assign line_wrap = (hpos == H_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpos <= '0;
      vpos <= '0;
    end else if (pix_en) begin
      hpos <= line_wrap ? '0 : hpos + 1'b1;
      if (line_wrap) vpos <= (vpos == V_LAST) ? '0 : vpos + 1'b1;
    end
  end

  assign hs_raw_n = !in_span(int'(hpos), H_VIS + H_FP, H_SY);
  assign vs_raw_n = !in_span(int'(vpos), V_VIS + V_FP, V_SY);

endmodule

// File: rtl/vga_frame_store.sv
module vga_frame_store #(
  parameter int WORDS = 6144,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/vga_reg_port.sv
module vga_reg_port #(
  parameter logic [31:0] BASE = 32'h3000_0000,
  parameter int FRAMES = 12,
  parameter int WORDS  = 6144,
  localparam int AW = $clog2(WORDS),
  localparam int FW = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [31:0]   bus_addr,
  input  logic [31:0]   bus_data,
  output logic          disp_en,
  output logic [FW-1:0] frame_sel,
  output logic [AW-1:0] ptr,
  output logic          base_hit,
  output logic          stream_wr,
  output logic [95:0]   pal_flat
);
  import vga_idx_pkg::*;

  localparam logic [AW-1:0] PTR_LAST = AW'(WORDS - 1);

  logic [7:0] ofs;
  logic       ctrl_wr;
  logic       pal_wr;
  logic [3:0] pal_idx;
  logic [3:0] fr_field;
  logic       fr_ok;

  assign base_hit  = (bus_addr[31:8] == BASE[31:8]);
  assign ofs       = bus_addr[7:0];
  assign ctrl_wr   = bus_wr && base_hit && (ofs == OFS_CTRL);
  assign stream_wr = bus_wr && base_hit && (ofs == OFS_STREAM);
  assign pal_wr    = bus_wr && base_hit && (ofs[7:6] == OFS_PAL_HI) && (ofs[1:0] == 2'b00);
  assign pal_idx   = ofs[5:2];
  assign fr_field  = bus_data[CTRL_FR_LSB +: 4];
  assign fr_ok     = ({1'b0, fr_field} < 5'(FRAMES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_en   <= 1'b0;
      frame_sel <= '0;
    end else if (ctrl_wr) begin
      disp_en <= bus_data[CTRL_EN_BIT];
      if (fr_ok) frame_sel <= FW'(fr_field);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ctrl_wr && bus_data[CTRL_PTR0_BIT]) begin
      ptr <= '0;
    end else if (stream_wr) begin
      ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    end
  end

  for (genvar n = 0; n < PAL_ENTRIES; n++) begin : g_pal
    logic [COLOR_W-1:0] entry;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   entry <= '0;
      else if (pal_wr && (pal_idx == 4'(n)))        entry <= bus_data[COLOR_W-1:0];
    end
    assign pal_flat[n*COLOR_W +: COLOR_W] = entry;
  end

endmodule

// File: rtl/vga_pixel_pipe.sv
module vga_pixel_pipe #(
  parameter int H_VIS  = 640,
  parameter int V_VIS  = 480,
  parameter int HW     = 10,
  parameter int VW     = 10,
  parameter int SRC    = 64,
  parameter int SCALE  = 6,
  parameter int FRAMES = 12,
  localparam int WPR   = SRC / 8,
  localparam int WPF   = SRC * WPR,
  localparam int WORDS = FRAMES * WPF,
  localparam int AW    = $clog2(WORDS),
  localparam int FW    = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int IMG   = SRC * SCALE,
  localparam int X0    = (H_VIS - IMG) / 2,
  localparam int Y0    = (V_VIS - IMG) / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [HW-1:0] hpos,
  input  logic [VW-1:0] vpos,
  input  logic          hs_raw_n,
  input  logic          vs_raw_n,
  input  logic          disp_en,
  input  logic [FW-1:0] frame_sel,
  input  logic [95:0]   pal_flat,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_word,
  output logic          s1_vis,
  output logic [5:0]    color,
  output logic          hsync_n,
  output logic          vsync_n
);
  import vga_idx_pkg::*;

  localparam logic [HW-1:0] X0_L = HW'(X0);
  localparam logic [VW-1:0] Y0_L = VW'(Y0);

  // word holding source pixel (col,row) of frame fr
  function automatic logic [AW-1:0] word_index(input logic [FW-1:0] fr,
                                                input logic [VW-1:0] row,
                                                input logic [HW-1:0] col);
    return AW'(fr) * AW'(WPF) + AW'(row) * AW'(WPR) + AW'(col >> 3);
  endfunction

  logic          win;
  logic [HW-1:0] sx, col;
  logic [VW-1:0] sy, row;

  assign win = in_span(int'(hpos), X0, IMG) && in_span(int'(vpos), Y0, IMG);
  assign sx  = hpos - X0_L;
  assign sy  = vpos - Y0_L;
  assign col = sx / HW'(SCALE);
  assign row = sy / VW'(SCALE);

  // stage 1: address and slot
  logic [2:0] s1_sel;
  logic       s1_hs_n, s1_vs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr <= '0;
      s1_sel  <= '0;
      s1_vis  <= 1'b0;
      s1_hs_n <= 1'b1;
      s1_vs_n <= 1'b1;
    end else if (pix_en) begin
      rd_addr <= word_index(frame_sel, row, col);
      s1_sel  <= col[2:0];
      s1_vis  <= win && disp_en;
      s1_hs_n <= hs_raw_n;
      s1_vs_n <= vs_raw_n;
    end
  end

  // stage 2: index extraction and table lookup
  logic [3:0] idx;
  assign idx = pick_nibble(rd_word, s1_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      color   <= '0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else if (pix_en) begin
      color   <= s1_vis ? pal_flat[idx*COLOR_W +: COLOR_W] : '0;
      hsync_n <= s1_hs_n;
      vsync_n <= s1_vs_n;
    end
  end

endmodule

// File: rtl/idx_vga_display.sv
module idx_vga_display #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 24,
  parameter int H_SY   = 40,
  parameter int H_BP   = 128,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 9,
  parameter int V_SY   = 3,
  parameter int V_BP   = 28,
  parameter int SRC    = 64,
  parameter int SCALE  = 6,
  parameter int FRAMES = 12,
  parameter logic [31:0] BASE = 32'h3000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_en,
  input  logic        bus_wr,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_data,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic [5:0]  color
);
  localparam int H_TOT = H_VIS + H_FP + H_SY + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SY + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);
  localparam int WORDS = FRAMES * SRC * (SRC / 8);
  localparam int AW    = $clog2(WORDS);
  localparam int FW    = (FRAMES > 1) ? $clog2(FRAMES) : 1;

  // named internal events, also seen by the checker
  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;
  logic          hs_raw_n, vs_raw_n;
  logic          disp_en;
  logic [FW-1:0] frame_sel;
  logic [AW-1:0] ptr;
  logic          base_hit;
  logic          stream_wr;
  logic [95:0]   pal_flat;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_word;
  logic          s1_vis;

  vga_scan_timer #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SY(H_SY), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SY(V_SY), .V_BP(V_BP)
  ) i_timer (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .hpos(hpos), .vpos(vpos), .hs_raw_n(hs_raw_n), .vs_raw_n(vs_raw_n)
  );

  vga_reg_port #(.BASE(BASE), .FRAMES(FRAMES), .WORDS(WORDS)) i_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_data(bus_data),
    .disp_en(disp_en), .frame_sel(frame_sel), .ptr(ptr), .base_hit(base_hit),
    .stream_wr(stream_wr), .pal_flat(pal_flat)
  );

  vga_frame_store #(.WORDS(WORDS)) i_store (
    .clk(clk), .we(stream_wr), .waddr(ptr), .wdata(bus_data),
    .raddr(rd_addr), .rdata(rd_word)
  );

  vga_pixel_pipe #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .HW(HW), .VW(VW),
    .SRC(SRC), .SCALE(SCALE), .FRAMES(FRAMES)
  ) i_pipe (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .hpos(hpos), .vpos(vpos), .hs_raw_n(hs_raw_n), .vs_raw_n(vs_raw_n),
    .disp_en(disp_en), .frame_sel(frame_sel), .pal_flat(pal_flat),
    .rd_addr(rd_addr), .rd_word(rd_word), .s1_vis(s1_vis),
    .color(color), .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

endmodule

// File: rtl/vga_idx_checker.sv
module vga_idx_checker #(
  parameter int H_TOT  = 832,
  parameter int FRAMES = 12,
  parameter int WORDS  = 6144,
  parameter int HW     = 10,
  parameter int AW     = 13,
  parameter int FW     = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          bus_wr,
  input logic [HW-1:0] hpos,
  input logic          disp_en,
  input logic [FW-1:0] frame_sel,
  input logic [AW-1:0] ptr,
  input logic          base_hit,
  input logic          stream_wr,
  input logic          s1_vis,
  input logic [5:0]    color,
  input logic          hsync_n,
  input logic          vsync_n
);

  assert_col_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hpos) < H_TOT);

  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(color) && $stable(hsync_n) && $stable(vsync_n) && $stable(hpos));

  assert_blank_is_black_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !s1_vis) |=> (color == 6'd0));

  assert_frame_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(frame_sel) < FRAMES);

  assert_ptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_wr && int'(ptr) != WORDS - 1) |=> (int'(ptr) == int'($past(ptr)) + 1));

  assert_ptr_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_wr && int'(ptr) == WORDS - 1) |=> (ptr == '0));

  assert_foreign_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !base_hit) |=> $stable(disp_en) && $stable(frame_sel) && $stable(ptr));

endmodule

bind idx_vga_display vga_idx_checker #(
  .H_TOT(H_TOT), .FRAMES(FRAMES), .WORDS(WORDS), .HW(HW), .AW(AW), .FW(FW)
) i_checker (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .bus_wr(bus_wr), .hpos(hpos),
  .disp_en(disp_en), .frame_sel(frame_sel), .ptr(ptr), .base_hit(base_hit),
  .stream_wr(stream_wr), .s1_vis(s1_vis), .color(color),
  .hsync_n(hsync_n), .vsync_n(vsync_n)
);

// File: tb/test_idx_vga_display.sv
module test_idx_vga_display;
  localparam int CLK_PERIOD = 10;
  // reduced geometry so whole frames fit in the run
  localparam int HV = 32, HF = 2, HS = 3, HB = 3;
  localparam int VV = 24, VF = 1, VS = 2, VB = 2;
  localparam int SRC = 8, SC = 2, FR = 3;
  localparam logic [31:0] BASE = 32'h3000_0000;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int WPR = SRC / 8, WPF = SRC * WPR, WORDS = FR * WPF;
  localparam int X0 = (HV - SRC * SC) / 2, Y0 = (VV - SRC * SC) / 2;

  logic clk = 0, rst_n = 0, pix_en = 0, bus_wr = 0;
  logic [31:0] bus_addr = 0, bus_data = 0;
  logic hsync_n, vsync_n;
  logic [5:0] color;

  idx_vga_display #(
    .H_VIS(HV), .H_FP(HF), .H_SY(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SY(VS), .V_BP(VB),
    .SRC(SRC), .SCALE(SC), .FRAMES(FR), .BASE(BASE)
  ) i_idx_vga_display (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, nz = 0, cyc = 0, pcnt = 0, pmode = 2;
  bit chk_on = 0, done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int mh, mv, mptr, mfr;
  bit men;
  int mpal [16];
  logic [31:0] mmem [WORDS];
  bit p_vis, p_hs, p_vs;
  int p_addr, p_sel;
  logic [5:0] e_color;
  logic e_hs, e_vs;

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mv = 0; mptr = 0; mfr = 0; men = 0;
      foreach (mpal[i]) mpal[i] = 0;
      p_vis = 0; p_hs = 1; p_vs = 1; p_addr = 0; p_sel = 0;
      e_color = 0; e_hs = 1; e_vs = 1;
    end else begin
      if (pix_en) begin
        e_color = p_vis ? 6'(mpal[(mmem[p_addr] >> (4 * p_sel)) & 32'hF]) : 6'd0;
        e_hs = p_hs; e_vs = p_vs;
        p_vis = men && mh >= X0 && mh < X0 + SRC * SC && mv >= Y0 && mv < Y0 + SRC * SC;
        if (p_vis) begin
          p_addr = mfr * WPF + ((mv - Y0) / SC) * WPR + ((mh - X0) / SC) / 8;
          p_sel  = ((mh - X0) / SC) % 8;
        end
        p_hs = !(mh >= HV + HF && mh < HV + HF + HS);
        p_vs = !(mv >= VV + VF && mv < VV + VF + VS);
        mh = mh + 1;
        if (mh == HT) begin mh = 0; mv = (mv + 1) % VT; end
      end
      if (bus_wr && bus_addr[31:8] == BASE[31:8]) begin
        int ofs;
        ofs = int'(bus_addr[7:0]);
        if (ofs == 0) begin
          men = bus_data[0];
          if (int'(bus_data[7:4]) < FR) mfr = int'(bus_data[7:4]);
          if (bus_data[8]) mptr = 0;
        end else if (ofs == 4) begin
          mmem[mptr] = bus_data;
          mptr = (mptr + 1) % WORDS;
        end else if (ofs >= 'h40 && ofs < 'h80 && ofs % 4 == 0) begin
          mpal[(ofs - 'h40) / 4] = int'(bus_data[5:0]);
        end
      end
    end
  end

  // pixel enable pattern, driven away from the active edge
  always @(negedge clk) begin
    pcnt++;
    case (pmode)
      0: pix_en = 1;
      1: pix_en = (pcnt % 3) != 0;
      default: pix_en = 0;
    endcase
  end

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n && chk_on && !done) begin
      checks += 3;
      if (color !== e_color) begin
        fails++; $display("FAIL %s color got %0h expected %0h at t=%0t", cur_req, color, e_color, $time);
      end
      if (hsync_n !== e_hs) begin
        fails++; $display("FAIL R2/R12 (%s) hsync_n got %b expected %b at t=%0t", cur_req, hsync_n, e_hs, $time);
      end
      if (vsync_n !== e_vs) begin
        fails++; $display("FAIL R3/R12 (%s) vsync_n got %b expected %b at t=%0t", cur_req, vsync_n, e_vs, $time);
      end
      if (color != 0) nz++;
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_data = d;
    @(negedge clk); bus_wr = 0; bus_addr = 0; bus_data = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_nz(input string req, input bit want_any);
    checks++;
    if ((nz > 0) != want_any) begin
      fails++; $display("FAIL %s non-zero pixel count got %0d expected %s", req, nz, want_any ? ">0" : "0");
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; fails++; checks++;
      $display("FAIL R4 watchdog cycles got %0d expected under 150000", cyc);
      summary(); $finish;
    end
  end

  initial begin
    run(5);
    @(negedge clk); rst_n = 1; chk_on = 1;
    cur_req = "R1"; run(4);                       // reset values, no pixel enable
    checks++;
    if (color !== 0 || hsync_n !== 1 || vsync_n !== 1) begin
      fails++; $display("FAIL R1 outputs got %0h/%b/%b expected 0/1/1", color, hsync_n, vsync_n);
    end
    pmode = 0;
    cur_req = "R7";                               // colour table, upper data bits ignored
    for (int n = 0; n < 16; n++) wr(BASE + 32'h40 + 32'(4 * n), 32'hABCD_EF00 | 32'((n * 7 + 5) & 63));
    cur_req = "R10";                              // stream all frames from word 0
    for (int i = 0; i < WORDS; i++) wr(BASE + 32'h4, 32'h1357_9BDF ^ (32'(i) * 32'h0F1E_2D3C));
    cur_req = "R8"; nz = 0; run(HT * 3);
    expect_nz("R8", 0);                           // display still off
    cur_req = "R6"; wr(BASE, 32'h01); nz = 0; run(HT * VT + 40);
    expect_nz("R5", 1);
    cur_req = "R4"; pmode = 1; wr(BASE, 32'h21); run(HT * VT * 3 / 2);
    pmode = 0;
    cur_req = "R9"; wr(BASE, 32'h71); run(HT * VT);
    cur_req = "R11"; nz = 0;
    wr(32'h3100_0000, 32'h0);                     // wrong base would disable
    wr(32'h2000_0040, 32'h3F);
    wr(BASE + 32'h08, 32'hDEAD_BEEF);
    wr(BASE + 32'h80, 32'h15);
    wr(BASE + 32'h42, 32'h2A);
    run(HT * VT);
    expect_nz("R11", 1);
    cur_req = "R7";                               // table rewrites during display
    for (int n = 0; n < 16; n += 3) wr(BASE + 32'h40 + 32'(4 * n), 32'((n * 11 + 9) & 63));
    run(HT * VT / 2);
    cur_req = "R10";                              // pointer reset, then wrap past the end
    wr(BASE, 32'h111);
    for (int i = 0; i < WORDS + 2; i++) wr(BASE + 32'h4, 32'hC0DE_0000 + 32'(i * 97));
    run(HT * VT);
    cur_req = "R8"; wr(BASE, 32'h10); run(8); nz = 0; run(HT * VT);
    expect_nz("R8", 0);
    done = 1;
    summary();
    $finish;
  end

endmodule